// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This controller sits beside a small CPU core and decides which of six request flags gets serviced next. The six sources are two external inputs, three timers and one serial port. Peripherals pulse a set line to raise a flag. Software can clear any flag through a clear strobe. The CPU reports the final cycle of each instruction, a return-from-handler strobe and writes to two configuration registers. The first register holds the per-source enables and a global enable. The second holds a per-source priority bit.

At the final cycle of an instruction, the controller looks at every pending, enabled request. It selects one winner, using the priority level first and a fixed source order second. The winner is announced with a one-cycle acknowledge that carries a 16-bit handler address. The controller keeps one in-service bit for each of the two levels. This lets a low-level handler be interrupted by a high-level request, while a high-level handler cannot be interrupted at all. Flags from the external inputs and from the two simple timers are cleared automatically when they win. The serial and third-timer flags stay set until software clears them.

Top module: `irq_arbiter`

## Requirements
- R1: The enable register keeps bits 0..5 (sources ext0, tmr0, ext1, tmr1, serial, tmr2 in that order) and bit 7 (global enable). Bit 6 always reads back 0. A source can win only when its own bit and bit 7 are both 1.
- R2: The priority register keeps bits 0..5 with the same source positions, where 1 means high level. Bits 7 and 6 read back 0, and the register resets to 00h.
- R3: A high-level request wins while only the low level is in service. No request wins while the high level is in service. A low-level request waits while any level is in service.
- R4: Among the winners' candidates at the same level, the lowest bit index wins, giving the order ext0, tmr0, ext1, tmr1, serial, tmr2.
- R5: The handler address is 0003h + 8 × (source index): 0003h, 000Bh, 0013h, 001Bh, 0023h, 002Bh.
- R6: When a source wins, its flag clears if the source is bit 0..3. Flags at bits 4 and 5 stay set. A flag_set pulse in the same cycle keeps the flag set.
- R7: Selection happens only in a cycle with instr_last=1. Selection is suppressed in any cycle with reti=1 or cfg_wr=1.
- R8: A reti strobe clears in_service[1] if it is set, and otherwise clears in_service[0]. in_service[1] is the high level.
- R9: Flags set and read back on the flags output whether or not their source is enabled. A disabled source never produces an acknowledge.
- R10: The acknowledge is high for exactly the one cycle after the selecting edge. At that same edge the winner's level bit in in_service is set. ack_vec is 0 whenever ack is 0.
- R11: After reset, all of the following are 0: flags, both registers, in_service, ack and ack_vec.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_set | input | 6 | One pulse per source event, sets the flag |
| flag_clr | input | 6 | Software clear of flags |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_sel | input | 1 | 0 selects enable register, 1 selects priority register |
| cfg_wdata | input | 8 | Write data |
| instr_last | input | 1 | Final cycle of the current instruction |
| reti | input | 1 | Return-from-handler strobe, in the instruction's final cycle |
| flags | output | 6 | Current request flags |
| en_reg | output | 8 | Enable register readback |
| pri_reg | output | 8 | Priority register readback |
| in_service | output | 2 | Levels in service, bit 1 high level |
| ack | output | 1 | One-cycle acknowledge |
| ack_vec | output | 16 | Handler address during ack |

## Verification
The bench builds the block with its default six sources and an auto-clear mask of 001111b. This brings both flag behaviours into reach: flags cleared by hardware and flags left for software. A directed sequence walks through the orderings, pre-emption, blocking strobes and nested returns. A long stimulus phase then drives random strobes and register values. This reaches combinations such as a return while both levels are in service, and a flag raised in the same cycle as its own acknowledge.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC = 6,
  parameter logic [NSRC-1:0] HWCLR = 6'b001111,
  parameter logic [15:0] VEC_BASE = 16'h0003,
  parameter logic [15:0] VEC_STEP = 16'h0008
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] flag_set,
  input  logic [NSRC-1:0] flag_clr,
  input  logic            cfg_wr,
  input  logic            cfg_sel,
  input  logic [7:0]      cfg_wdata,
  input  logic            instr_last,
  input  logic            reti,
  output logic [NSRC-1:0] flags,
  output logic [7:0]      en_reg,
  output logic [7:0]      pri_reg,
  output logic [1:0]      in_service,
  output logic            ack,
  output logic [15:0]     ack_vec
);
  localparam int GEN_BIT = 7;
  localparam int IDX_W = $clog2(NSRC);
  localparam logic [7:0] SRC_MASK = 8'((1 << NSRC) - 1);
  localparam logic [7:0] EN_MASK = SRC_MASK | 8'(1 << GEN_BIT);

  logic [NSRC-1:0] live, hi_cand, lo_cand;
  logic            poll, win_ok, win_hi;
  logic [IDX_W-1:0] win_idx;
  logic [1:0]      ins_n;

  assign live    = flags & en_reg[NSRC-1:0] & {NSRC{en_reg[GEN_BIT]}};
  assign hi_cand = live & pri_reg[NSRC-1:0];
  assign lo_cand = live & ~pri_reg[NSRC-1:0];
  assign poll    = instr_last & ~reti & ~cfg_wr;

  always_comb begin
    win_ok  = 1'b0;
    win_hi  = 1'b0;
    win_idx = '0;
    if (poll && !in_service[1] && |hi_cand) begin
      win_ok = 1'b1;
      win_hi = 1'b1;
      for (int i = NSRC-1; i >= 0; i--)
        if (hi_cand[i]) win_idx = IDX_W'(i);
    end else if (poll && in_service == 2'b00 && |lo_cand) begin
      win_ok = 1'b1;
      for (int i = NSRC-1; i >= 0; i--)
        if (lo_cand[i]) win_idx = IDX_W'(i);
    end
  end

  always_comb begin
    ins_n = in_service;
    if (reti) begin
      if (in_service[1]) ins_n[1] = 1'b0;
      else               ins_n[0] = 1'b0;
    end
    if (win_ok) ins_n[win_hi] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_reg     <= '0;
      pri_reg    <= '0;
      in_service <= '0;
      ack        <= 1'b0;
      ack_vec    <= '0;
    end else begin
      if (cfg_wr && !cfg_sel) en_reg  <= cfg_wdata & EN_MASK;
      if (cfg_wr &&  cfg_sel) pri_reg <= cfg_wdata & SRC_MASK;
      in_service <= ins_n;
      ack        <= win_ok;
      ack_vec    <= win_ok ? VEC_BASE + VEC_STEP * 16'(win_idx) : 16'h0000;
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_flag
    logic drop;
    if (HWCLR[g]) begin : g_auto
      assign drop = flag_clr[g] | (win_ok & (win_idx == IDX_W'(g)));
    end else begin : g_sw
      assign drop = flag_clr[g];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) flags[g] <= 1'b0;
      else        flags[g] <= flag_set[g] | (flags[g] & ~drop);
    end
  end

  AST_HIGH_NOT_PREEMPTED: assert property (@(posedge clk) disable iff (!rst_n) in_service[1] |=> !ack); // R3
  AST_BLOCKED_BY_STROBE: assert property (@(posedge clk) disable iff (!rst_n) (reti || cfg_wr) |=> !ack); // R7
  AST_ONLY_AT_FINAL: assert property (@(posedge clk) disable iff (!rst_n) !instr_last |=> !ack); // R7
  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n) !en_reg[GEN_BIT] |=> !ack); // R1
  AST_ACK_MARKS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) ack |-> in_service != 2'b00); // R10
  AST_ACK_SINGLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) (ack && in_service == 2'b01) |=> !ack || in_service == 2'b11); // R3
  AST_BIT6_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !en_reg[6]); // R1
endmodule

// File: tb/sim_irq_arbiter.sv
module sim_irq_arbiter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] flag_set = '0, flag_clr = '0;
  logic cfg_wr = 1'b0, cfg_sel = 1'b0, instr_last = 1'b0, reti = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [5:0] flags;
  logic [7:0] en_reg, pri_reg;
  logic [1:0] in_service;
  logic ack;
  logic [15:0] ack_vec;

  int checks = 0, fails = 0;
  bit cmp_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .flag_set(flag_set), .flag_clr(flag_clr),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .instr_last(instr_last), .reti(reti), .flags(flags), .en_reg(en_reg),
    .pri_reg(pri_reg), .in_service(in_service), .ack(ack), .ack_vec(ack_vec)
  );

  // behavioural reference
  int m_en = 0, m_pri = 0, m_flag = 0, m_ins = 0, m_ack = 0, m_vec = 0;
  always @(posedge clk) begin
    int win, lvl, nf, ni;
    if (!rst_n) begin
      m_en = 0; m_pri = 0; m_flag = 0; m_ins = 0; m_ack = 0; m_vec = 0;
    end else begin
      win = -1; lvl = 0;
      if (instr_last && !reti && !cfg_wr && m_en[7]) begin
        if ((m_ins & 2) == 0)
          for (int i = 0; i < 6; i++)
            if (win < 0 && m_flag[i] && m_en[i] && m_pri[i]) begin win = i; lvl = 1; end
        if (win < 0 && m_ins == 0)
          for (int i = 0; i < 6; i++)
            if (win < 0 && m_flag[i] && m_en[i] && !m_pri[i]) win = i;
      end
      nf = m_flag;
      if (win >= 0 && win < 4) nf = nf & ~(1 << win);
      nf = (nf & ~int'(flag_clr)) | int'(flag_set);
      ni = m_ins;
      if (reti) ni = (m_ins & 2) ? (ni & 1) : (ni & 2);
      if (win >= 0) ni = ni | (lvl ? 2 : 1);
      if (cfg_wr && !cfg_sel) m_en = cfg_wdata & 8'hBF;
      if (cfg_wr && cfg_sel) m_pri = cfg_wdata & 8'h3F;
      m_flag = nf; m_ins = ni;
      m_ack = (win >= 0);
      m_vec = (win >= 0) ? 3 + 8 * win : 0;
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h expected=%0h at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk("R10 ack", int'(ack), m_ack);
    chk("R5 vector", int'(ack_vec), m_vec);
    chk("R6 flags", int'(flags), m_flag);
    chk("R8 in_service", int'(in_service), m_ins);
    chk("R1 enable", int'(en_reg), m_en);
    chk("R2 priority", int'(pri_reg), m_pri);
  end

  task automatic tick(input logic last, input logic rt, input logic wr, input logic sel,
                      input logic [7:0] d, input logic [5:0] st, input logic [5:0] cl);
    instr_last = last; reti = rt; cfg_wr = wr; cfg_sel = sel; cfg_wdata = d;
    flag_set = st; flag_clr = cl;
    @(posedge clk); @(negedge clk);
    instr_last = 0; reti = 0; cfg_wr = 0; cfg_sel = 0; cfg_wdata = 0;
    flag_set = 0; flag_clr = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 flags", int'(flags), 0);
    chk("R11 ack", int'(ack), 0);
    chk("R11 in_service", int'(in_service), 0);
    chk("R2 pri reset", int'(pri_reg), 0);
    chk("R11 en", int'(en_reg), 0);
    rst_n = 1; cmp_on = 1;
    tick(0,0,0,0,8'h00,6'h04,6'h00); chk("R9 flag visible", int'(flags), 4);
    tick(1,0,0,0,8'h00,6'h00,6'h00); chk("R1 no enable", int'(ack), 0);
    tick(0,0,1,0,8'h04,6'h00,6'h00);
    tick(1,0,0,0,8'h00,6'h00,6'h00); chk("R1 no global", int'(ack), 0);
    tick(1,0,1,0,8'hC4,6'h00,6'h00);
    chk("R1 bit6 dropped", int'(en_reg), 8'h84);
    chk("R7 write blocks", int'(ack), 0);
    tick(1,0,0,0,8'h00,6'h00,6'h00);
    chk("R10 ack", int'(ack), 1);
    chk("R5 ext1 vec", int'(ack_vec), 16'h0013);
    chk("R6 ext1 cleared", int'(flags), 0);
    chk("R10 level set", int'(in_service), 1);
    tick(0,0,0,0,8'h00,6'h00,6'h00);
    chk("R10 one cycle", int'(ack), 0);
    chk("R10 vec idle", int'(ack_vec), 0);
    tick(0,0,1,0,8'h85,6'h00,6'h00);
    tick(0,0,0,0,8'h00,6'h01,6'h00);
    tick(1,0,0,0,8'h00,6'h00,6'h00); chk("R3 equal level waits", int'(ack), 0);
    tick(0,0,1,1,8'hF1,6'h00,6'h00); chk("R2 pri masked", int'(pri_reg), 8'h31);
    tick(0,0,1,1,8'h01,6'h00,6'h00);
    tick(1,0,0,0,8'h00,6'h00,6'h00);
    chk("R3 high preempts", int'(ack_vec), 16'h0003);
    chk("R3 both levels", int'(in_service), 3);
    tick(0,0,1,1,8'h05,6'h00,6'h00);
    tick(0,0,0,0,8'h00,6'h04,6'h00);
    tick(1,0,0,0,8'h00,6'h00,6'h00); chk("R3 high not preempted", int'(ack), 0);
    tick(1,1,0,0,8'h00,6'h00,6'h00);
    chk("R7 reti blocks", int'(ack), 0);
    chk("R8 pops high", int'(in_service), 1);
    tick(1,0,0,0,8'h00,6'h00,6'h00); chk("R3 high after pop", int'(ack_vec), 16'h0013);
    tick(0,1,0,0,8'h00,6'h00,6'h00);
    tick(0,1,0,0,8'h00,6'h00,6'h00); chk("R8 pops low", int'(in_service), 0);
    tick(0,0,1,1,8'h00,6'h00,6'h00);
    tick(0,0,1,0,8'hBF,6'h00,6'h00);
    tick(0,0,0,0,8'h00,6'h3C,6'h00);
    tick(1,0,0,0,8'h00,6'h00,6'h00); chk("R4 ext1 first", int'(ack_vec), 16'h0013);
    tick(0,1,0,0,8'h00,6'h00,6'h00);
    tick(1,0,0,0,8'h00,6'h00,6'h00); chk("R4 tmr1 next", int'(ack_vec), 16'h001B);
    tick(0,1,0,0,8'h00,6'h00,6'h00);
    tick(1,0,0,0,8'h00,6'h00,6'h00);
    chk("R5 serial vec", int'(ack_vec), 16'h0023);
    chk("R6 serial kept", int'(flags), 6'h30);
    tick(0,1,0,0,8'h00,6'h00,6'h00);
    tick(1,0,0,0,8'h00,6'h00,6'h00); chk("R4 serial before tmr2", int'(ack_vec), 16'h0023);
    tick(0,1,0,0,8'h00,6'h00,6'h10);
    tick(1,0,0,0,8'h00,6'h00,6'h00);
    chk("R5 tmr2 vec", int'(ack_vec), 16'h002B);
    chk("R6 tmr2 kept", int'(flags), 6'h20);
    tick(0,1,0,0,8'h00,6'h00,6'h20);
    tick(0,0,1,0,8'hBD,6'h00,6'h00);
    tick(0,0,0,0,8'h00,6'h02,6'h00);
    tick(1,0,0,0,8'h00,6'h00,6'h00);
    chk("R9 disabled no ack", int'(ack), 0);
    chk("R9 disabled flag set", int'(flags), 6'h02);
    for (int k = 0; k < 4000; k++) begin
      automatic logic [5:0] st = ($urandom % 4 == 0) ? 6'($urandom) : 6'h00;
      automatic logic [5:0] cl = ($urandom % 6 == 0) ? 6'($urandom) : 6'h00;
      automatic logic wr = ($urandom % 24 == 0);
      tick(1'($urandom), ($urandom % 10 == 0), wr, 1'($urandom),
           8'($urandom) | 8'h80, st, cl);
    end
    cmp_on = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule